// File: doc/BRIEF.md
# Segmented Page-Table Walk Address Generator

This block services one translation miss at a time for a memory system that splits each address space into segments and gives every segment its own linear page table. A 32-bit virtual address arrives on a request port. The two top bits pick the segment, the next eighteen bits form the virtual page number, and the low twelve bits are the byte offset within a 4 KB page. The block selects that segment's page-table base and page-count limit. It rejects unused segments and out-of-range pages without touching memory. Otherwise it computes the entry address, which is the base plus four times the page number. It issues a single read and turns the returned 32-bit entry into either a physical address or a fault code.

Software loads each segment's base and page count through a one-cycle configuration write. The block is busy from the cycle after it accepts a request until it presents the one-cycle response. Requests offered while it is busy are not taken. The memory side uses a read request with valid/ready and a response valid strobe of any latency.

The walk runs through five named states. IDLE waits for a request. CHECK tests the segment and bound and latches the entry address. ISSUE holds the read request until memory takes it. WAIT waits for the entry. RESP presents the result for one cycle. The transitions are: IDLE to CHECK on an accepted request. CHECK to RESP on a segment or bound fault, and CHECK to ISSUE otherwise. ISSUE to WAIT on the read handshake. WAIT to RESP on the response strobe. RESP to IDLE unconditionally.

Top module: `seg_ptw_top`

## Requirements
- R1: After reset `busy`, `rsp_valid` and `mem_rd_valid` are low, and every segment's base and page count are zero, so any translation before configuration faults with code 2.
- R2: Virtual address bits [31:30] select the segment: 01, 10 and 11 each use their own base and page count; the page number is bits [29:12] and the offset bits [11:0].
- R3: Segment 00 returns fault code 1 and issues no memory read.
- R4: A page number greater than or equal to the selected segment's page count returns fault code 2 and issues no memory read; a count of zero rejects every page.
- R5: The read address is the selected base plus the page number times 4, modulo 2^32. `mem_rd_valid` and `mem_rd_addr` are held steady until `mem_rd_ready` is seen.
- R6: A returned entry with bit 0 clear gives fault code 3. Every fault response carries a physical address of zero.
- R7: A returned entry with bit 0 set gives code 0 and physical address {entry[31:12], offset}.
- R8: `busy` is high from the cycle after a request is accepted through the response cycle. `req_valid` while busy is ignored and produces no further response.
- R9: Each accepted request yields exactly one single-cycle `rsp_valid` pulse. For codes 1 and 2 this pulse comes two clock edges after the accepting edge. For codes 0 and 3 it comes one edge after the edge that samples `mem_rsp_valid`.
- R10: A configuration write targets the base when `cfg_sel` is 0 and the page count when it is 1, for the segment given by `cfg_seg`. A write to segment 0 changes nothing. A base write landing on the same edge as CHECK does not alter that walk's read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_seg | input | 2 | Segment targeted by the write |
| cfg_sel | input | 1 | 0 = base, 1 = page count |
| cfg_wdata | input | 32 | Write data (page count uses low 19 bits) |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | Walk in progress; new requests not taken |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_code | output | 2 | 0 ok, 1 unused segment, 2 out of bounds, 3 invalid entry |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Entry address |
| mem_rsp_valid | input | 1 | Entry data strobe |
| mem_rsp_data | input | 32 | Returned entry |

## Verification
A request driven before an edge is accepted there, so `busy` is already high at the following falling edge. For fault codes 1 and 2, the bench expects `rsp_valid` at the second falling edge after the request is driven. For memory-backed results, the pulse is due at the falling edge right after the edge that sees `mem_rsp_valid`. The memory model randomises ready and latency, so this delay varies from walk to walk. Each walk counts falling edges until the pulse and checks that count for fault results. It also counts the read handshakes to confirm that faults issue none. One cycle after the pulse, it checks that `rsp_valid` and `busy` are both low again.

// File: rtl/seg_ptw_pkg.sv
package seg_ptw_pkg;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_UNUSED    = 2'd1,
        FLT_BOUNDS    = 2'd2,
        FLT_BAD_ENTRY = 2'd3
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } walk_st_e;

endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs #(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 2,
    parameter int BND_W  = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_seg,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [SEG_W-1:0]  rd_seg,
    output logic [ADDR_W-1:0] rd_base,
    output logic [BND_W-1:0]  rd_bound
);
    localparam int NUM_SEG = (1 << SEG_W) - 1;

    logic [NUM_SEG:0][ADDR_W-1:0] base_vec;
    logic [NUM_SEG:0][BND_W-1:0]  bnd_vec;

    // slot 0 is the unused segment: no storage behind it
    assign base_vec[0] = '0;
    assign bnd_vec[0]  = '0;

    for (genvar g = 1; g <= NUM_SEG; g++) begin : g_seg
        logic [ADDR_W-1:0] base_q;
        logic [BND_W-1:0]  bnd_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                bnd_q  <= '0;
            end else if (cfg_we && cfg_seg == SEG_W'(g)) begin
                if (cfg_sel) bnd_q  <= cfg_wdata[BND_W-1:0];
                else         base_q <= cfg_wdata;
            end
        end
        assign base_vec[g] = base_q;
        assign bnd_vec[g]  = bnd_q;
    end

    assign rd_base  = base_vec[rd_seg];
    assign rd_bound = bnd_vec[rd_seg];

endmodule

// File: rtl/seg_addr_decode.sv
module seg_addr_decode
    import seg_ptw_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PA_W     = 32,
    parameter int SEG_W    = 2,
    parameter int OFFS_W   = 12,
    parameter int PTE_LOG2 = 2,
    parameter int BND_W    = 19
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PA_W-1:0]  base,
    input  logic [BND_W-1:0] bound,
    output logic [SEG_W-1:0] seg,
    output logic [PA_W-1:0]  pte_addr,
    output flt_e             fault
);
    localparam int VPN_W = VA_W - SEG_W - OFFS_W;

    logic [VPN_W-1:0] vpn;
    logic [PA_W-1:0]  vpn_ext;

    assign seg      = vaddr[VA_W-1 -: SEG_W];
    assign vpn      = vaddr[OFFS_W +: VPN_W];
    assign vpn_ext  = PA_W'(vpn);
    assign pte_addr = base + (vpn_ext << PTE_LOG2);

    always_comb begin
        if (seg == '0)                           fault = FLT_UNUSED;
        else if (BND_W'(vpn) >= bound)           fault = FLT_BOUNDS;
        else                                     fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_walk_fsm.sv
module seg_walk_fsm
    import seg_ptw_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int OFFS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic [VA_W-1:0]  vaddr_q,
    input  logic [PA_W-1:0]  dec_pte_addr,
    input  flt_e             dec_fault,
    output logic             busy,
    output logic             rsp_valid,
    output flt_e             rsp_code,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PA_W-1:0]  mem_rsp_data
);
    walk_st_e st_q, st_d;
    logic [PA_W-1:0] addr_q;
    logic [PA_W-1:0] paddr_q;
    flt_e            code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_valid) st_d = ST_CHECK;
            ST_CHECK: st_d = (dec_fault == FLT_NONE) ? ST_ISSUE : ST_RESP;
            ST_ISSUE: if (mem_rd_ready) st_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) st_d = ST_RESP;
            ST_RESP:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            addr_q  <= '0;
            paddr_q <= '0;
            code_q  <= FLT_NONE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) vaddr_q <= req_vaddr;
                ST_CHECK: begin
                    addr_q  <= dec_pte_addr;
                    code_q  <= dec_fault;
                    paddr_q <= '0;
                end
                ST_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_data[0]) begin
                        code_q  <= FLT_NONE;
                        paddr_q <= {mem_rsp_data[PA_W-1:OFFS_W], vaddr_q[OFFS_W-1:0]};
                    end else begin
                        code_q  <= FLT_BAD_ENTRY;
                        paddr_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy         = (st_q != ST_IDLE);
        mem_rd_valid = (st_q == ST_ISSUE);
        mem_rd_addr  = addr_q;
        rsp_valid    = (st_q == ST_RESP);
        rsp_code     = code_q;
        rsp_paddr    = paddr_q;
    end

    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r8_busy_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    a_r4_no_read_before_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code == FLT_BOUNDS || rsp_code == FLT_UNUSED)) |-> !$past(mem_rd_valid));

    a_r6_fault_paddr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != FLT_NONE) |-> (rsp_paddr == '0));

    a_r7_ok_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == FLT_NONE) |-> $past(mem_rsp_valid));

endmodule

// File: rtl/seg_ptw_top.sv
module seg_ptw_top
    import seg_ptw_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PA_W     = 32,
    parameter int SEG_W    = 2,
    parameter int OFFS_W   = 12,
    parameter int PTE_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_seg,
    input  logic              cfg_sel,
    input  logic [PA_W-1:0]   cfg_wdata,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              busy,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [PA_W-1:0]   mem_rsp_data
);
    localparam int VPN_W = VA_W - SEG_W - OFFS_W;
    localparam int BND_W = VPN_W + 1;

    logic [VA_W-1:0]  vaddr_q;
    logic [SEG_W-1:0] seg;
    logic [PA_W-1:0]  sel_base;
    logic [BND_W-1:0] sel_bound;
    logic [PA_W-1:0]  pte_addr;
    flt_e             fault;
    flt_e             code;

    seg_cfg_regs #(.ADDR_W(PA_W), .SEG_W(SEG_W), .BND_W(BND_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rd_seg(seg), .rd_base(sel_base), .rd_bound(sel_bound)
    );

    seg_addr_decode #(.VA_W(VA_W), .PA_W(PA_W), .SEG_W(SEG_W), .OFFS_W(OFFS_W),
                      .PTE_LOG2(PTE_LOG2), .BND_W(BND_W)) u_dec (
        .vaddr(vaddr_q), .base(sel_base), .bound(sel_bound),
        .seg(seg), .pte_addr(pte_addr), .fault(fault)
    );

    seg_walk_fsm #(.VA_W(VA_W), .PA_W(PA_W), .OFFS_W(OFFS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .vaddr_q(vaddr_q),
        .dec_pte_addr(pte_addr), .dec_fault(fault),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_code(code), .rsp_paddr(rsp_paddr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    assign rsp_code = code;

endmodule

// File: tb/seg_ptw_top_tb.sv
module seg_ptw_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_seg = '0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        busy, rsp_valid, mem_rd_valid;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_paddr, mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    int rd_count = 0;
    logic [31:0] cap_addr = '0;
    logic [31:0] base_m [4];
    logic [31:0] bnd_m [4];

    always #2 clk = ~clk;

    seg_ptw_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_vaddr(req_vaddr), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] pte_of(input logic [31:0] a);
        return {a[21:2] ^ 20'hA5A5A, 11'h155, (a[4:2] != 3'b111)};
    endfunction

    function automatic void model(input logic [31:0] va, output logic [1:0] code,
                                  output logic [31:0] pa, output logic [31:0] ad);
        logic [1:0]  s = va[31:30];
        logic [17:0] vpn = va[29:12];
        logic [31:0] e;
        pa = '0; ad = '0;
        if (s == 2'b00) code = 2'd1;
        else if ({14'b0, vpn} >= bnd_m[s]) code = 2'd2;
        else begin
            ad = base_m[s] + {12'b0, vpn, 2'b00};
            e  = pte_of(ad);
            code = e[0] ? 2'd0 : 2'd3;
            if (e[0]) pa = {e[31:12], va[11:0]};
        end
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // memory model: random ready, random latency
    initial begin
        forever begin
            @(negedge clk);
            mem_rd_ready = 1'b0;
            if (mem_rd_valid && ($urandom % 2 == 0)) begin
                mem_rd_ready = 1'b1;
                cap_addr = mem_rd_addr;
                rd_count++;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                repeat ($urandom % 4) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pte_of(cap_addr);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic cfg_write(input logic [1:0] s, input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_seg = s; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s != 2'b00) begin
            if (sel) bnd_m[s] = {13'b0, d[18:0]};
            else     base_m[s] = d;
        end
    endtask

    task automatic do_xlate(input logic [31:0] va, input bit ghost, input bit midcfg);
        logic [1:0]  ec;
        logic [31:0] ep, ea;
        int rd0;
        int n;
        bit got;
        model(va, ec, ep, ea);
        rd0 = rd_count;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        chk("R8 busy after accept", {31'b0, busy}, 32'd1);
        if (ghost) req_vaddr = 32'h4000_3000;
        else       req_valid = 1'b0;
        if (midcfg) begin
            cfg_we = 1'b1; cfg_seg = 2'b10; cfg_sel = 1'b0; cfg_wdata = 32'h0BAD_0000;
        end
        n = 0; got = 0;
        while (!got && n < 60) begin
            @(negedge clk);
            n++;
            if (rsp_valid) got = 1;
            req_valid = 1'b0;
            cfg_we = 1'b0;
        end
        if (midcfg) base_m[2] = 32'h0BAD_0000;
        chk("R9 response arrives", {31'b0, got}, 32'd1);
        if (ec == 2'd1)      chk("R3 code", {30'b0, rsp_code}, {30'b0, ec});
        else if (ec == 2'd2) chk("R4 code", {30'b0, rsp_code}, {30'b0, ec});
        else if (ec == 2'd3) chk("R6 code", {30'b0, rsp_code}, {30'b0, ec});
        else                 chk("R7 code", {30'b0, rsp_code}, {30'b0, ec});
        if (ec == 2'd0) chk("R7 paddr", rsp_paddr, ep);
        else            chk("R6 fault paddr", rsp_paddr, ep);
        if (ec == 2'd1 || ec == 2'd2) begin
            chk("R3 R4 no read", rd_count - rd0, 32'd0);
            chk("R9 fault latency", n, 32'd1);
        end else begin
            chk("R5 one read", rd_count - rd0, 32'd1);
            chk("R5 entry addr", cap_addr, ea);
        end
        @(negedge clk);
        chk("R9 single pulse", {31'b0, rsp_valid}, 32'd0);
        chk("R8 idle after rsp", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin base_m[i] = '0; bnd_m[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R1 busy reset", {31'b0, busy}, 32'd0);
        chk("R1 rsp_valid reset", {31'b0, rsp_valid}, 32'd0);
        chk("R1 mem_rd_valid reset", {31'b0, mem_rd_valid}, 32'd0);
        rst_n = 1'b1;
        do_xlate(32'h4000_0123, 0, 0);          // R1 zero bounds -> code 2

        cfg_write(2'b01, 1'b0, 32'h0010_0000);  // R10 code base
        cfg_write(2'b01, 1'b1, 32'd3);
        cfg_write(2'b10, 1'b0, 32'h0020_0400);
        cfg_write(2'b10, 1'b1, 32'd8);
        cfg_write(2'b11, 1'b0, 32'hFFFF_FFF0);
        cfg_write(2'b11, 1'b1, 32'h0004_0000);

        do_xlate(32'h4000_2ABC, 0, 0);          // R2 code vpn 2 ok
        do_xlate(32'h4000_3000, 0, 0);          // R4 vpn == bound
        do_xlate(32'h0001_2345, 0, 0);          // R3 unused segment
        do_xlate(32'h8000_7FFF, 0, 0);          // R6 heap vpn 7 invalid entry
        do_xlate(32'h8000_5001, 1, 0);          // R8 ghost request ignored
        do_xlate(32'hFFFF_FFFF, 0, 0);          // R5 stack max vpn, address wraps
        do_xlate(32'hC000_0000, 0, 0);          // R2 stack vpn 0
        cfg_write(2'b00, 1'b0, 32'h1234_5678);  // R10 segment 0 write ignored
        cfg_write(2'b00, 1'b1, 32'h0000_0001);
        do_xlate(32'h4000_1010, 0, 0);
        do_xlate(32'h0000_0000, 0, 0);
        do_xlate(32'h8000_1444, 0, 1);          // R10 mid-walk base write
        do_xlate(32'h8000_1444, 0, 0);          // R10 new base in effect
        cfg_write(2'b10, 1'b1, 32'd0);          // R4 zero bound
        do_xlate(32'h8000_0000, 0, 0);
        cfg_write(2'b10, 1'b1, 32'd64);

        for (int k = 0; k < 80; k++) begin
            logic [1:0]  s = 2'($urandom % 4);
            logic [17:0] v;
            if (s == 2'b11) v = 18'($urandom);
            else            v = 18'($urandom % (bnd_m[s] * 2 + 2));
            do_xlate({s, v, 12'($urandom)}, k[0], 0);
        end

        summary();
        $finish;
    end

endmodule